// File: doc/BRIEF.md
# Processor Sideband Control Generator

This block produces the legacy control lines that a system I/O hub presents to a processor. It generates a fixed-length, active-low init pulse. The pulse can be requested by software, by a falling edge on the keyboard controller's reset request, or by PCI reset when built-in self-test support is selected. It also drives the interrupt request line and a latched non-maskable interrupt line. During PCI reset, the interrupt line and the NMI line carry frequency-strap values instead.

Two simpler outputs complete the block. The address-20 mask output is the OR of the keyboard controller's A20 gate and the hub's other mask sources. The processor power-good output is an open-drain pull-down enable. All logic runs on the PCI clock. Asynchronous inputs from the keyboard controller and the error lines pass through a two-flop synchronizer before their edges are detected. Every output comes straight from a flop.

Top module: `cpu_sideband_ctrl`

## Requirements
- R1: Each init request drives `init_n` low for exactly PULSE_LEN (default 16) consecutive cycles. A one-cycle `sw_init` pulse captured at edge E makes `init_n` low after edges E through E+15 and high after edge E+16.
- R2: A high-to-low change on `kbc_rst_n` is an init request. Its synchronized edge starts the pulse, so `init_n` goes low two edges after the edge that first captures the new level.
- R3: A falling edge on `kbc_rst_n` whose detection cycle sees `sleep_xition` high is ignored, and no init pulse follows it.
- R4: A new request arriving while a pulse runs reloads the full count. `init_n` then stays low until PULSE_LEN cycles after the latest request.
- R5: While `bist_en` and `pci_rst` are both high, `init_n` is held low, with one cycle of register delay. After they clear, `init_n` returns high once no counted pulse remains.
- R6: A rising edge on `serr` or `iochk` sets the NMI latch. The `nmi` output goes high three edges after the edge that captures the rising level.
- R7: A high on `nmi_clr` clears the NMI latch, and `nmi` falls on the following edge. If a set and a clear meet in the same cycle, the set wins.
- R8: While `pci_rst` is high, `intr` is driven with `strap_intr` and `nmi` with `strap_nmi`, each one edge later. The NMI latch is held clear during that time.
- R9: Outside PCI reset, `intr` follows `intr_req` one edge later (high means pending).
- R10: `a20m` is the OR of `kbc_a20` and `a20_other`, registered one edge later.
- R11: `pwrgd_pull_low` is high unless both `pwrok` and `vrm_ok` are high, registered one edge later.
- R12: After `rst`, `init_n` is 1, `intr` is 0, `nmi` is 0, `a20m` is 0 and `pwrgd_pull_low` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high block reset |
| pci_rst | input | 1 | PCI reset active (high) |
| kbc_rst_n | input | 1 | Keyboard controller reset request, active low, asynchronous |
| kbc_a20 | input | 1 | Keyboard controller A20 gate |
| a20_other | input | 1 | Other A20 mask sources, pre-ORed |
| serr | input | 1 | System error, active high, asynchronous |
| iochk | input | 1 | I/O check error, active high, asynchronous |
| nmi_clr | input | 1 | NMI source control write that clears the latch |
| pwrok | input | 1 | Platform power good |
| vrm_ok | input | 1 | Voltage regulator power good |
| sleep_xition | input | 1 | Sleep-state transition in progress |
| bist_en | input | 1 | Self-test option: init follows PCI reset |
| strap_intr | input | 1 | Frequency-strap bit for the interrupt line |
| strap_nmi | input | 1 | Frequency-strap bit for the NMI line |
| sw_init | input | 1 | Software init request, one-cycle pulse |
| intr_req | input | 1 | Interrupt pending from the interrupt controller |
| init_n | output | 1 | Init pulse to the processor, active low |
| intr | output | 1 | Interrupt request line |
| nmi | output | 1 | Non-maskable interrupt line |
| a20m | output | 1 | Address-20 mask, active high |
| pwrgd_pull_low | output | 1 | Open-drain enable for processor power good |

## Verification
Two collisions can land in one cycle. The first is a new init request while a pulse is already counting. The bench issues a second software request eight cycles into a pulse and expects `init_n` to stay low through the sixteenth cycle after the second request. It then expects `init_n` to go high on the next cycle. The second collision is an NMI set meeting a clear. The bench times an `nmi_clr` pulse to the edge where a synchronized `iochk` rising edge sets the latch, and expects `nmi` to stay high afterwards.

// File: rtl/cpu_sb_pkg.sv
package cpu_sb_pkg;
  localparam int SYNC_BITS = 3;
  localparam int IDX_KBC   = 0;
  localparam int IDX_SERR  = 1;
  localparam int IDX_IOCHK = 2;
  // idle (reset) level of each synchronized input: kbc reset request rests high
  localparam logic [SYNC_BITS-1:0] SYNC_IDLE = 3'b001;
endpackage

// File: rtl/sb_sync_edge.sv
module sb_sync_edge #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
      prev <= IDLE;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign rise = stg[STAGES-1] & ~prev;
  assign fall = ~stg[STAGES-1] & prev;
endmodule

// File: rtl/sb_init_pulse.sv
module sb_init_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic hold,
  output logic init_n
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    if (req)              cnt_nxt = CNT_W'(PULSE_LEN);
    else if (cnt != '0)   cnt_nxt = cnt - CNT_W'(1);
    else                  cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      init_n <= 1'b1;
    end else begin
      cnt    <= cnt_nxt;
      init_n <= (cnt_nxt == '0) && !hold;
    end
  end

  a_r1_reload: assert property (@(posedge clk) disable iff (rst)
    req |=> (cnt == CNT_W'(PULSE_LEN)));
  a_r1_countdown: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !req) |=> (cnt == $past(cnt) - CNT_W'(1)));
  a_r4_req_low: assert property (@(posedge clk) disable iff (rst)
    req |=> !init_n);
  a_r5_hold_low: assert property (@(posedge clk) disable iff (rst)
    hold |=> !init_n);
endmodule

// File: rtl/sb_nmi_latch.sv
module sb_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic hold_clear,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst || hold_clear) flag <= 1'b0;
    else if (set)          flag <= 1'b1;
    else if (clr)          flag <= 1'b0;
  end

  a_r6_set: assert property (@(posedge clk) disable iff (rst)
    (set && !hold_clear) |=> flag);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag);
  a_r8_held_clear: assert property (@(posedge clk) disable iff (rst)
    hold_clear |=> !flag);
endmodule

// File: rtl/cpu_sideband_ctrl.sv
module cpu_sideband_ctrl #(
  parameter int PULSE_LEN = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pci_rst,
  input  logic kbc_rst_n,
  input  logic kbc_a20,
  input  logic a20_other,
  input  logic serr,
  input  logic iochk,
  input  logic nmi_clr,
  input  logic pwrok,
  input  logic vrm_ok,
  input  logic sleep_xition,
  input  logic bist_en,
  input  logic strap_intr,
  input  logic strap_nmi,
  input  logic sw_init,
  input  logic intr_req,
  output logic init_n,
  output logic intr,
  output logic nmi,
  output logic a20m,
  output logic pwrgd_pull_low
);
  import cpu_sb_pkg::*;

  logic [SYNC_BITS-1:0] async_in, rise, fall;
  logic kbc_req, init_req, nmi_set, nmi_flag;

  assign async_in[IDX_KBC]   = kbc_rst_n;
  assign async_in[IDX_SERR]  = serr;
  assign async_in[IDX_IOCHK] = iochk;

  sb_sync_edge #(.N(SYNC_BITS), .STAGES(SYNC_STAGES), .IDLE(SYNC_IDLE)) u_sync (
    .clk(clk), .rst(rst), .din(async_in), .rise(rise), .fall(fall));

  assign kbc_req  = fall[IDX_KBC] && !sleep_xition;
  assign init_req = kbc_req || sw_init;
  assign nmi_set  = rise[IDX_SERR] || rise[IDX_IOCHK];

  sb_init_pulse #(.PULSE_LEN(PULSE_LEN)) u_init (
    .clk(clk), .rst(rst), .req(init_req), .hold(bist_en && pci_rst),
    .init_n(init_n));

  sb_nmi_latch u_nmi (
    .clk(clk), .rst(rst), .set(nmi_set), .clr(nmi_clr),
    .hold_clear(pci_rst), .flag(nmi_flag));

  always_ff @(posedge clk) begin
    if (rst) begin
      intr           <= 1'b0;
      nmi            <= 1'b0;
      a20m           <= 1'b0;
      pwrgd_pull_low <= 1'b1;
    end else begin
      intr           <= pci_rst ? strap_intr : intr_req;
      nmi            <= pci_rst ? strap_nmi  : nmi_flag;
      a20m           <= kbc_a20 || a20_other;
      pwrgd_pull_low <= !(pwrok && vrm_ok);
    end
  end

  a_r3_sleep_mask: assert property (@(posedge clk) disable iff (rst)
    (init_n && fall[IDX_KBC] && sleep_xition && !sw_init && !(bist_en && pci_rst))
      |=> init_n);
  a_r8_strap_intr: assert property (@(posedge clk) disable iff (rst)
    pci_rst |=> (intr == $past(strap_intr)));
  a_r9_intr_follow: assert property (@(posedge clk) disable iff (rst)
    !pci_rst |=> (intr == $past(intr_req)));
  a_r10_a20_or: assert property (@(posedge clk) disable iff (rst)
    (kbc_a20 || a20_other) |=> a20m);
  a_r11_pwrgd: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pwrgd_pull_low == !$past(pwrok && vrm_ok)));
endmodule

// File: tb/cpu_sideband_ctrl_test.sv
module cpu_sideband_ctrl_test;
  logic clk = 0;
  logic rst = 1;
  logic pci_rst = 0, kbc_rst_n = 1, kbc_a20 = 0, a20_other = 0, serr = 0, iochk = 0;
  logic nmi_clr = 0, pwrok = 0, vrm_ok = 0, sleep_xition = 0, bist_en = 0;
  logic strap_intr = 0, strap_nmi = 0, sw_init = 0, intr_req = 0;
  logic init_n, intr, nmi, a20m, pwrgd_pull_low;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { int at; int sig; bit val; string req; } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cpu_sideband_ctrl uut (
    .clk(clk), .rst(rst), .pci_rst(pci_rst), .kbc_rst_n(kbc_rst_n), .kbc_a20(kbc_a20),
    .a20_other(a20_other), .serr(serr), .iochk(iochk), .nmi_clr(nmi_clr),
    .pwrok(pwrok), .vrm_ok(vrm_ok), .sleep_xition(sleep_xition), .bist_en(bist_en),
    .strap_intr(strap_intr), .strap_nmi(strap_nmi), .sw_init(sw_init),
    .intr_req(intr_req), .init_n(init_n), .intr(intr), .nmi(nmi), .a20m(a20m),
    .pwrgd_pull_low(pwrgd_pull_low));

  function automatic bit pick(int sig);
    case (sig)
      0: pick = init_n;
      1: pick = intr;
      2: pick = nmi;
      3: pick = a20m;
      default: pick = pwrgd_pull_low;
    endcase
  endfunction

  task automatic check(string req, string name, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, name, act, exp, cyc);
    end
  endtask

  task automatic expect_at(int at, int sig, bit val, string req);
    item_t it;
    it.at = at; it.sig = sig; it.val = val; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compare scoreboard items due this cycle, away from the active edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        check(sb[i].req, $sformatf("sig%0d", sb[i].sig), pick(sb[i].sig), sb[i].val);
        sb.delete(i);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sw_init(output int now);
    @(negedge clk); sw_init = 1; now = cyc;
    @(negedge clk); sw_init = 0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    int now, t1;
    step(3);
    rst = 0;
    step(1);
    // R12 reset state
    check("R12", "init_n", init_n, 1);
    check("R12", "intr", intr, 0);
    check("R12", "nmi", nmi, 0);
    check("R12", "a20m", a20m, 0);
    check("R12", "pwrgd_pull_low", pwrgd_pull_low, 1);
    step(4);

    // R1 software init pulse length
    pulse_sw_init(now);
    expect_at(now + 1, 0, 0, "R1");
    expect_at(now + 16, 0, 0, "R1");
    expect_at(now + 17, 0, 1, "R1");
    step(24);

    // R2 keyboard reset falling edge
    @(negedge clk); kbc_rst_n = 0; now = cyc;
    expect_at(now + 2, 0, 1, "R2");
    expect_at(now + 3, 0, 0, "R2");
    expect_at(now + 18, 0, 0, "R2");
    expect_at(now + 19, 0, 1, "R2");
    step(4); kbc_rst_n = 1;
    step(24);

    // R3 keyboard reset ignored during sleep transition
    @(negedge clk); sleep_xition = 1; kbc_rst_n = 0; now = cyc;
    expect_at(now + 3, 0, 1, "R3");
    expect_at(now + 5, 0, 1, "R3");
    expect_at(now + 8, 0, 1, "R3");
    step(4); kbc_rst_n = 1;
    step(6); sleep_xition = 0;
    step(4);

    // R4 retrigger restarts the count
    pulse_sw_init(now);
    step(6);
    pulse_sw_init(t1);
    expect_at(now + 17, 0, 0, "R4");
    expect_at(t1 + 16, 0, 0, "R4");
    expect_at(t1 + 17, 0, 1, "R4");
    step(26);

    // R5 BIST hold and R8 strap values during PCI reset
    @(negedge clk); bist_en = 1; pci_rst = 1; strap_intr = 1; strap_nmi = 1; now = cyc;
    expect_at(now + 1, 0, 0, "R5");
    expect_at(now + 1, 1, 1, "R8");
    expect_at(now + 1, 2, 1, "R8");
    expect_at(now + 25, 0, 0, "R5");
    step(30);
    @(negedge clk); pci_rst = 0; now = cyc;
    expect_at(now + 1, 0, 1, "R5");
    expect_at(now + 1, 1, 0, "R9");
    expect_at(now + 1, 2, 0, "R8");
    step(2); bist_en = 0; strap_intr = 0; strap_nmi = 0;
    step(4);

    // R9 interrupt follows request
    @(negedge clk); intr_req = 1; now = cyc;
    expect_at(now + 1, 1, 1, "R9");
    step(3); intr_req = 0; now = cyc;
    expect_at(now + 1, 1, 0, "R9");
    step(4);

    // R6 NMI from system error
    @(negedge clk); serr = 1; now = cyc;
    expect_at(now + 3, 2, 0, "R6");
    expect_at(now + 4, 2, 1, "R6");
    step(6); serr = 0;
    step(4);
    // R7 clear
    @(negedge clk); nmi_clr = 1; now = cyc;
    @(negedge clk); nmi_clr = 0;
    expect_at(now + 2, 2, 0, "R7");
    step(4);
    // R6 NMI from I/O check
    @(negedge clk); iochk = 1; now = cyc;
    expect_at(now + 4, 2, 1, "R6");
    step(6); iochk = 0;
    @(negedge clk); nmi_clr = 1;
    @(negedge clk); nmi_clr = 0;
    step(6);
    // R7 set and clear meet in one cycle: set wins
    @(negedge clk); iochk = 1; now = cyc;
    step(2); nmi_clr = 1;
    @(negedge clk); nmi_clr = 0;
    expect_at(now + 4, 2, 1, "R7");
    expect_at(now + 6, 2, 1, "R7");
    step(8); iochk = 0;
    @(negedge clk); nmi_clr = 1;
    @(negedge clk); nmi_clr = 0;
    step(3);

    // R10 A20 mask OR
    @(negedge clk); kbc_a20 = 1; now = cyc;
    expect_at(now + 1, 3, 1, "R10");
    step(2); kbc_a20 = 0; a20_other = 1; now = cyc;
    expect_at(now + 1, 3, 1, "R10");
    step(2); a20_other = 0; now = cyc;
    expect_at(now + 1, 3, 0, "R10");
    step(3);

    // R11 power good
    @(negedge clk); pwrok = 1; now = cyc;
    expect_at(now + 1, 4, 1, "R11");
    step(2); vrm_ok = 1; now = cyc;
    expect_at(now + 1, 4, 0, "R11");
    step(2); pwrok = 0; now = cyc;
    expect_at(now + 1, 4, 1, "R11");
    step(4);

    step(4);
    foreach (sb[i]) begin
      failures++;
      $display("FAIL %s item never checked actual=pending expected=checked", sb[i].req);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule